// File: doc/BRIEF.md
# Triggered Circular Capture Buffer

This block records a multi-channel stream of one-bit samples into an on-chip ring memory with no pause. Each clock brings one 256-bit input word that holds four consecutive 64-channel samples, so one ring of 512 words keeps the most recent 2048 samples. Because writing never stops, the samples that came before a trigger are already stored when the trigger arrives.

When a trigger is accepted, the block keeps writing for a programmed number of words and then freezes that ring. The count is the post-trigger length minus a latency-compensation value, both given in words of four samples. The block then reports which ring froze and the word address of its oldest sample, and pulses a completion strobe. Writing continues at once in the second ring, so no sample is lost. Both rings share one dual-port memory: a 256-bit write port, and a 32-bit read port that a downstream transfer engine uses to drain the frozen event. A frozen ring stays protected until the reader acknowledges it.

With a post length of 384 words and no compensation, a frozen ring holds 512 pre-trigger and 1536 post-trigger samples.

Top module: `trig_ring_capture`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `evt_done_o` is 0, `evt_first_o` is 0 and `evt_buf_o` is 0. After reset, writing starts in ring 0.
- R2: Every clock edge with `rst` low writes `samp_word_i` into the active ring at word address n mod 512, where n counts the edges since reset was released, starting at 0. The pointer never pauses, including across a ring change.
- R3: A trigger accepted at the edge that writes word index nT makes words nT to nT+N-1 the post-trigger part. `evt_done_o` is high for exactly one cycle, right after the edge that writes index nT+N-1.
- R4: With the strobe, `evt_first_o` gives the oldest word of the frozen ring, (nT+N) mod 512. `evt_buf_o` gives the ring that froze. Both hold their values until the next strobe.
- R5: N is computed from `post_words_i` (P) and `comp_words_i` (C), sampled at the trigger edge. P of 0 counts as 1, and P above 512 counts as 512. N is P-C when C < P and 1 otherwise.
- R6: The first write after the edge that writes the last post-trigger word goes into the other ring, so successive events alternate ring 0, ring 1, ring 0 and so on.
- R7: A frozen ring is not written again until it has been acknowledged and has become active once more.
- R8: A trigger that arrives while a post-trigger countdown is running is ignored. The event completes at the time set by the first trigger.
- R9: After a strobe, triggers are ignored until `rd_ack_i` is seen high at a clock edge. A trigger that arrives at the same edge as the acknowledge is also ignored.
- R10: `rd_addr_i` is {ring (bit 12), word (bits 11:3), lane (bits 2:0)}. The cycle after the edge that samples it, `rd_data_o` equals bits lane*32+31 down to lane*32 of that stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_word_i | input | 256 | Four 64-channel samples, oldest in bits 63:0 |
| trig_i | input | 1 | Trigger request, sampled each edge |
| post_words_i | input | 10 | Post-trigger length in words |
| comp_words_i | input | 10 | Latency compensation in words |
| rd_ack_i | input | 1 | Releases the frozen ring |
| rd_addr_i | input | 13 | Read address {ring, word, lane} |
| rd_data_o | output | 32 | Read data, one cycle after the address |
| evt_done_o | output | 1 | One-cycle event-complete strobe |
| evt_buf_o | output | 1 | Ring holding the finished event |
| evt_first_o | output | 9 | Word address of the oldest sample of the event |

## Verification
A write pointer that is off by even one word moves `evt_first_o` and the data read back from the oldest, newest and trigger words. This shows up in the first event, a few cycles after the strobe. A countdown that is loaded wrongly, or that restarts on a second trigger, moves the strobe away from the expected cycle for each of the length settings, including the clamped ones. A ring-select or hold-state fault shows up in the next event as a wrong `evt_buf_o`, as a strobe while a ring is still unacknowledged, or as live data where frozen data should have been read back.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_POST  = 2'd1,
    ST_HOLD  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/trc_len.sv
module trc_len #(
  parameter int CNT_W     = 10,
  parameter int BUF_WORDS = 512
) (
  input  logic [CNT_W-1:0] post_i,
  input  logic [CNT_W-1:0] comp_i,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] MAXW = CNT_W'(BUF_WORDS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] post_c;

  always_comb begin
    if (post_i == '0)       post_c = ONE;
    else if (post_i > MAXW) post_c = MAXW;
    else                    post_c = post_i;
    if (comp_i >= post_c)   len_o = ONE;
    else                    len_o = post_c - comp_i;
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int WORD_W    = 256,
  parameter int RD_W      = 32,
  parameter int BUF_WORDS = 512,
  localparam int WA_W  = $clog2(BUF_WORDS),
  localparam int LANES = WORD_W / RD_W,
  localparam int LA_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic [WA_W:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WA_W:0]     raddr_i,
  input  logic [LA_W-1:0]   rlane_i,
  output logic [RD_W-1:0]   rdata_o
);
  logic [WORD_W-1:0] mem [2*BUF_WORDS];
  logic [WORD_W-1:0] rword_q;
  logic [LA_W-1:0]   rlane_q;
  logic [RD_W-1:0]   lane_w [LANES];

  always_ff @(posedge clk) begin
    mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rword_q <= mem[raddr_i];
    rlane_q <= rlane_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = rword_q[g*RD_W +: RD_W];
  end

  assign rdata_o = lane_w[rlane_q];
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int CNT_W     = 10,
  localparam int WA_W = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [WA_W:0]    waddr_o,
  output logic             done_o,
  output logic             buf_o,
  output logic [WA_W-1:0]  first_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cap_state_e       st_q;
  logic [WA_W-1:0]  wptr_q;
  logic             act_q;
  logic [CNT_W-1:0] remain_q;
  logic             finish;

  always_comb begin
    finish = 1'b0;
    if (st_q == ST_WATCH && trig_i && len_i == ONE) finish = 1'b1;
    if (st_q == ST_POST && remain_q == ONE)         finish = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_WATCH;
      wptr_q   <= '0;
      act_q    <= 1'b0;
      remain_q <= '0;
      done_o   <= 1'b0;
      buf_o    <= 1'b0;
      first_o  <= '0;
    end else begin
      wptr_q <= wptr_q + 1'b1;
      done_o <= 1'b0;
      case (st_q)
        ST_WATCH: if (trig_i && !finish) begin
          remain_q <= len_i - ONE;
          st_q     <= ST_POST;
        end
        ST_POST:  if (!finish) remain_q <= remain_q - ONE;
        ST_HOLD:  if (ack_i) st_q <= ST_WATCH;
        default:  st_q <= ST_WATCH;
      endcase
      if (finish) begin
        act_q   <= ~act_q;
        buf_o   <= act_q;
        first_o <= wptr_q + 1'b1;
        done_o  <= 1'b1;
        st_q    <= ST_HOLD;
      end
    end
  end

  assign waddr_o = {act_q, wptr_q};
endmodule

// File: rtl/trig_ring_capture.sv
module trig_ring_capture #(
  parameter int CHANNELS         = 64,
  parameter int SAMPLES_PER_WORD = 4,
  parameter int BUF_WORDS        = 512,
  parameter int RD_W             = 32,
  localparam int WORD_W = CHANNELS * SAMPLES_PER_WORD,
  localparam int WA_W   = $clog2(BUF_WORDS),
  localparam int CNT_W  = WA_W + 1,
  localparam int LA_W   = $clog2(WORD_W / RD_W),
  localparam int RA_W   = 1 + WA_W + LA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] samp_word_i,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  post_words_i,
  input  logic [CNT_W-1:0]  comp_words_i,
  input  logic              rd_ack_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic              evt_done_o,
  output logic              evt_buf_o,
  output logic [WA_W-1:0]   evt_first_o
);
  logic [CNT_W-1:0] len_w;
  logic [WA_W:0]    waddr_w;

  trc_len #(.CNT_W(CNT_W), .BUF_WORDS(BUF_WORDS)) u_len (
    .post_i (post_words_i),
    .comp_i (comp_words_i),
    .len_o  (len_w)
  );

  trc_ctrl #(.BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_i),
    .ack_i   (rd_ack_i),
    .len_i   (len_w),
    .waddr_o (waddr_w),
    .done_o  (evt_done_o),
    .buf_o   (evt_buf_o),
    .first_o (evt_first_o)
  );

  trc_ram #(.WORD_W(WORD_W), .RD_W(RD_W), .BUF_WORDS(BUF_WORDS)) u_ram (
    .clk     (clk),
    .waddr_i (waddr_w),
    .wdata_i (samp_word_i),
    .raddr_i (rd_addr_i[RA_W-1:LA_W]),
    .rlane_i (rd_addr_i[LA_W-1:0]),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int WA_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            evt_done,
  input logic            evt_buf,
  input logic [WA_W-1:0] evt_first,
  input logic            rd_ack
);
  logic owed_q, seen_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= 1'b0;
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (evt_done) begin
        owed_q <= !rd_ack;
        seen_q <= 1'b1;
        last_q <= evt_buf;
      end else if (rd_ack) begin
        owed_q <= 1'b0;
      end
    end
  end

  // R1: quiet outputs coming out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!evt_done && evt_first == '0 && !evt_buf));

  // R3: completion strobe lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> !evt_done);

  // R4: reported address only moves with the strobe
  p_first_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !evt_done |-> ($stable(evt_first) && $stable(evt_buf)));

  // R6: successive events come from alternating rings
  p_buf_alt_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_done && seen_q) |-> (evt_buf != last_q));

  // R9: no new event while the previous one is unacknowledged
  p_ack_gate_r9: assert property (@(posedge clk) disable iff (rst)
    evt_done |-> !owed_q);
endmodule

bind trig_ring_capture trc_checker #(.WA_W(WA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_done  (evt_done_o),
  .evt_buf   (evt_buf_o),
  .evt_first (evt_first_o),
  .rd_ack    (rd_ack_i)
);

// File: tb/trig_ring_capture_tb_top.sv
module trig_ring_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] samp;
  logic         trig = 1'b0;
  logic [9:0]   post = '0;
  logic [9:0]   comp = '0;
  logic         ack = 1'b0;
  logic [12:0]  rd_addr = '0;
  logic [31:0]  rd_data;
  logic         done;
  logic         ebuf;
  logic [8:0]   efirst;

  int n = 0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic exp_buf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] lane_val(int idx, int l);
    return {idx[23:0], 8'(l)};
  endfunction

  function automatic logic [255:0] pat(int idx);
    logic [255:0] r;
    for (int l = 0; l < 8; l++) r[l*32 +: 32] = lane_val(idx, l);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end
  assign samp = pat(n);

  trig_ring_capture dut_i (
    .clk          (clk),
    .rst          (rst),
    .samp_word_i  (samp),
    .trig_i       (trig),
    .post_words_i (post),
    .comp_words_i (comp),
    .rd_ack_i     (ack),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .evt_done_o   (done),
    .evt_buf_o    (ebuf),
    .evt_first_o  (efirst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic b, input int w, input int l, output logic [31:0] v);
    @(negedge clk);
    rd_addr = {b, 9'(w), 3'(l)};
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
    chk(efirst == 9'd0, "R1 first in reset", 32'(efirst), 0);
    chk(ebuf == 1'b0, "R1 ring in reset", 32'(ebuf), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && efirst == 9'd0, "R1 after release", 32'(efirst), 0);
  endtask

  // one event: R3 R4 R5 R6 R7 R8 R10
  task automatic t_capture(input int p, input int c, input int expn, input int extra, input bit do_ack);
    int nt, nd, lst;
    bit seen;
    logic [31:0] v;
    logic b;
    idle(520);
    post = 10'(p);
    comp = 10'(c);
    trig = 1'b1;
    nt = n;
    seen = 0;
    nd = -1;
    for (int k = 0; k < 700; k++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        nd = n;
        break;
      end
      trig = (k == extra) ? 1'b1 : 1'b0;
    end
    trig = 1'b0;
    chk(seen && nd == nt + expn, "R3 R5 R8 strobe timing", 32'(nd - nt), 32'(expn));
    chk(efirst == 9'((nt + expn) % DEPTH), "R4 oldest address", 32'(efirst), 32'((nt + expn) % DEPTH));
    chk(ebuf == exp_buf, "R6 ring of event", 32'(ebuf), 32'(exp_buf));
    @(negedge clk);
    chk(done == 1'b0, "R3 strobe single cycle", 32'(done), 0);
    b = exp_buf;
    exp_buf = ~exp_buf;
    lst = nt + expn - 1;
    idle(40);
    rd(b, (lst + 1) % DEPTH, 3, v);
    chk(v == lane_val(lst - 511, 3), "R7 R10 oldest word", v, lane_val(lst - 511, 3));
    rd(b, lst % DEPTH, 7, v);
    chk(v == lane_val(lst, 7), "R7 R10 newest word", v, lane_val(lst, 7));
    rd(b, nt % DEPTH, 0, v);
    chk(v == lane_val(nt, 0), "R7 R10 trigger word", v, lane_val(nt, 0));
    if (do_ack) begin
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
    end
  endtask

  // R2 R6: live writes land at n mod 512 in the new active ring
  task automatic t_live();
    int idx;
    logic [31:0] v;
    idle(10);
    idx = n - 3;
    rd(exp_buf, idx % DEPTH, 5, v);
    chk(v == lane_val(idx, 5), "R2 R6 live write position", v, lane_val(idx, 5));
  endtask

  // R9: triggers held off until acknowledge
  task automatic t_block();
    int cnt;
    cnt = 0;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, "R9 trigger while unacknowledged", 32'(cnt), 0);
    ack = 1'b1;
    trig = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    trig = 1'b0;
    cnt = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, "R9 trigger at acknowledge edge", 32'(cnt), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_capture(384, 0, 384, -1, 1'b1);
    t_live();
    t_capture(200, 50, 150, 20, 1'b1);
    t_capture(0, 0, 1, -1, 1'b1);
    t_capture(100, 300, 1, -1, 1'b1);
    t_capture(700, 0, 512, -1, 1'b1);
    t_capture(64, 0, 64, 10, 1'b0);
    t_block();
    t_capture(10, 2, 8, -1, 1'b1);
    t_live();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule